// File: doc/BRIEF.md
# Analog Input Scan Sequencer

This block sequences a multiplexed analog acquisition. Software loads a list of up to sixteen conversion slots, each naming a multiplexer channel, a gain code and a unipolar flag. It then picks a first and a last slot. Each accepted conversion trigger applies the current slot's settings to the front-end outputs and pulses a start strobe to the converter. When the converter returns a result word, the word is stored in a sample FIFO and the slot pointer moves on. After the last slot the pointer returns to the first slot and an end-of-scan event is flagged.

Software reaches the block through a small register port with two address bits. Writes select the control, list or mode register. Reads return the oldest sample, the status word, or a flush action. A pending end-of-conversion or end-of-scan flag raises the interrupt line when its enable bit is set. Reading the status word clears both pending flags. An optional external start gate holds off every conversion trigger until a start pulse is seen.

Top module: `ai_scan_seq`

## Requirements
- R1: After reset the status word reads FIFO-empty (bit 1) set, with FIFO full (bit 2), busy (bit 15) and end-of-scan (bit 13) clear. `irq` is low and the front-end outputs are zero.
- R2: A write to address 1 stores a list slot. The slot index is in bits 11:8, the unipolar flag in bit 7, the gain code in bits 5:4 and the channel in bits 3:0. A conversion on that slot drives these values on `mux_chan`, `gain` and `unipolar`.
- R3: A trigger that is sampled while the block is idle and allowed to start produces a one-cycle `conv_start` strobe in the next cycle. Status bit 15 reads 1 from that strobe until a result arrives, and reads 0 otherwise, so 0 means no conversion is in progress. A trigger that arrives during a conversion starts nothing.
- R4: When mode bit 3 is set, each result moves the slot pointer up by one. A result taken on the last slot reloads the pointer with the first slot and sets end-of-scan (status bit 13). When mode bit 3 is clear, the pointer stays where it is.
- R5: A write to address 0 sets the first slot from bits 3:0 and the last slot from bits 11:8. The same write reloads the pointer with the first slot and abandons any conversion in progress.
- R6: When control bit 15 is set, conversion triggers are ignored until a pulse on `ext_start` is seen. Writing the control register clears that armed state.
- R7: Each result word is pushed into the sample FIFO. A read at address 0 pops the oldest word. Status bit 1 reports empty and bit 2 reports full. A result that arrives while the FIFO is full is discarded.
- R8: A read at address 0 while the FIFO is empty returns the last word popped and leaves the FIFO unchanged.
- R9: A read at address 3 empties the sample FIFO.
- R10: `irq` equals (end-of-conversion pending AND mode bit 0) OR (end-of-scan pending AND mode bit 1). A status read at address 1 clears both pending flags.
- R11: Status bits 7:4 return the `REVISION` parameter, and bits 11:8 return the `din` lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid in the cycle after `rd_en` |
| conv_trig | input | 1 | Conversion trigger pulse from a timer |
| ext_start | input | 1 | External start pulse |
| adc_valid | input | 1 | Converter result valid |
| adc_data | input | 16 | Converter result word |
| din | input | 4 | Digital input lines reported in status |
| conv_start | output | 1 | Converter start strobe |
| mux_chan | output | 4 | Multiplexer channel of the current conversion |
| gain | output | 2 | Gain code of the current conversion |
| unipolar | output | 1 | Unipolar flag of the current conversion |
| irq | output | 1 | Interrupt request |

## Verification
A trigger that is sampled at one edge shows `conv_start` and the new front-end settings after that same edge. The bench therefore samples them at the following falling edge. A result that is sampled with `adc_valid` is in the FIFO, in the pointer and in the pending flags right after that edge, and `irq` follows combinationally. Register reads return data one edge after `rd_en`. The bench drives every stimulus on falling edges and compares at the next falling edge. It keeps a scoreboard of expected slot settings, which is popped on each strobe, and a FIFO model of expected data and status words.

// File: rtl/aiseq_pkg.sv
package aiseq_pkg;

    localparam int IDX_W = 4;

    // register addresses
    typedef enum logic [1:0] {
        A_CTRL_FIFO = 2'd0,
        A_LIST_STAT = 2'd1,
        A_MODE      = 2'd2,
        A_FLUSH     = 2'd3
    } addr_e;

    typedef struct packed {
        logic       unipolar;
        logic [1:0] gain;
        logic [3:0] mux;
    } slot_t;

    typedef struct packed {
        logic             ext_gate;
        logic [IDX_W-1:0] last_idx;
        logic [IDX_W-1:0] first_idx;
    } ctrl_t;

    typedef struct packed {
        logic scan_en;
        logic eos_ie;
        logic eoc_ie;
    } mode_t;

    function automatic slot_t slot_from_word(input logic [15:0] w);
        slot_t s;
        s.unipolar = w[7];
        s.gain     = w[5:4];
        s.mux      = w[3:0];
        return s;
    endfunction

    function automatic ctrl_t ctrl_from_word(input logic [15:0] w);
        ctrl_t c;
        c.ext_gate  = w[15];
        c.last_idx  = w[11:8];
        c.first_idx = w[3:0];
        return c;
    endfunction

    function automatic mode_t mode_from_word(input logic [15:0] w);
        mode_t m;
        m.scan_en = w[3];
        m.eos_ie  = w[1];
        m.eoc_ie  = w[0];
        return m;
    endfunction

endpackage

// File: rtl/aiseq_list.sv
module aiseq_list
    import aiseq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  slot_t            wslot,
    input  logic [IDX_W-1:0] ridx,
    output slot_t            rslot
);
    slot_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[widx] <= wslot;
        end
    end

    assign rslot = mem[ridx];
endmodule

// File: rtl/aiseq_fifo.sv
module aiseq_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    input  logic         flush,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;
    logic [W-1:0]  last_q;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign dout    = empty ? last_q : mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
            last_q <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop) begin
                rd_ptr <= bump(rd_ptr);
                last_q <= mem[rd_ptr];
            end
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/aiseq_seq.sv
module aiseq_seq
    import aiseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [IDX_W-1:0] restart_idx,
    input  logic             trig,
    input  logic             ext_start,
    input  logic             ext_gate,
    input  logic             scan_en,
    input  logic [IDX_W-1:0] first_idx,
    input  logic [IDX_W-1:0] last_idx,
    input  logic             adc_valid,
    output logic             launch,
    output logic             conv_start,
    output logic             busy,
    output logic             eoc_evt,
    output logic             eos_evt,
    output logic [IDX_W-1:0] cur_idx
);
    logic armed_q;

    assign launch  = trig && !busy && (!ext_gate || armed_q) && !restart;
    assign eoc_evt = busy && adc_valid && !restart;
    assign eos_evt = eoc_evt && scan_en && (cur_idx == last_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_idx    <= '0;
            busy       <= 1'b0;
            conv_start <= 1'b0;
            armed_q    <= 1'b0;
        end else if (restart) begin
            cur_idx    <= restart_idx;
            busy       <= 1'b0;
            conv_start <= 1'b0;
            armed_q    <= 1'b0;
        end else begin
            conv_start <= launch;
            if (launch)       busy <= 1'b1;
            else if (eoc_evt) busy <= 1'b0;
            if (ext_start) armed_q <= 1'b1;
            if (eoc_evt && scan_en)
                cur_idx <= eos_evt ? first_idx : cur_idx + 1'b1;
        end
    end
endmodule

// File: rtl/ai_scan_seq.sv
module ai_scan_seq
    import aiseq_pkg::*;
#(
    parameter int         LIST_DEPTH = 16,
    parameter int         FIFO_DEPTH = 8,
    parameter logic [3:0] REVISION   = 4'h3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [1:0]  addr,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    input  logic        conv_trig,
    input  logic        ext_start,
    input  logic        adc_valid,
    input  logic [15:0] adc_data,
    input  logic [3:0]  din,
    output logic        conv_start,
    output logic [3:0]  mux_chan,
    output logic [1:0]  gain,
    output logic        unipolar,
    output logic        irq
);
    ctrl_t ctrl_q, ctrl_new;
    mode_t mode_q;
    slot_t cur_slot, out_q;
    logic  eoc_ie_q, eos_ie_q;
    logic  wr_ctrl, wr_list, wr_mode, rd_fifo, rd_stat, rd_flush;
    logic  launch, busy, eoc_evt, eos_evt;
    logic  eoc_pend, eos_pend;
    logic  fifo_full, fifo_empty;
    logic [15:0] fifo_dout, status;
    logic [IDX_W-1:0] cur_idx;
    logic  unused_bits;

    assign wr_ctrl  = wr_en && (addr == A_CTRL_FIFO);
    assign wr_list  = wr_en && (addr == A_LIST_STAT);
    assign wr_mode  = wr_en && (addr == A_MODE);
    assign rd_fifo  = rd_en && (addr == A_CTRL_FIFO);
    assign rd_stat  = rd_en && (addr == A_LIST_STAT);
    assign rd_flush = rd_en && (addr == A_FLUSH);
    assign ctrl_new = ctrl_from_word(wdata);
    assign unused_bits = ^{wdata[14:12], wdata[6], wdata[2]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            mode_q <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_new;
            if (wr_mode) mode_q <= mode_from_word(wdata);
        end
    end
    assign eoc_ie_q = mode_q.eoc_ie;
    assign eos_ie_q = mode_q.eos_ie;

    aiseq_list #(.DEPTH(LIST_DEPTH)) u_list (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_list),
        .widx  (wdata[11:8]),
        .wslot (slot_from_word(wdata)),
        .ridx  (cur_idx),
        .rslot (cur_slot)
    );

    aiseq_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .restart     (wr_ctrl),
        .restart_idx (ctrl_new.first_idx),
        .trig        (conv_trig),
        .ext_start   (ext_start),
        .ext_gate    (ctrl_q.ext_gate),
        .scan_en     (mode_q.scan_en),
        .first_idx   (ctrl_q.first_idx),
        .last_idx    (ctrl_q.last_idx),
        .adc_valid   (adc_valid),
        .launch      (launch),
        .conv_start  (conv_start),
        .busy        (busy),
        .eoc_evt     (eoc_evt),
        .eos_evt     (eos_evt),
        .cur_idx     (cur_idx)
    );

    aiseq_fifo #(.DEPTH(FIFO_DEPTH), .W(16)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (eoc_evt),
        .din   (adc_data),
        .pop   (rd_fifo),
        .flush (rd_flush),
        .dout  (fifo_dout),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    // front-end settings latched when a conversion launches
    always_ff @(posedge clk) begin
        if (rst)         out_q <= '0;
        else if (launch) out_q <= cur_slot;
    end
    assign mux_chan = out_q.mux;
    assign gain     = out_q.gain;
    assign unipolar = out_q.unipolar;

    always_ff @(posedge clk) begin
        if (rst) begin
            eoc_pend <= 1'b0;
            eos_pend <= 1'b0;
        end else begin
            if (eoc_evt)      eoc_pend <= 1'b1;
            else if (rd_stat) eoc_pend <= 1'b0;
            if (eos_evt)      eos_pend <= 1'b1;
            else if (rd_stat) eos_pend <= 1'b0;
        end
    end
    assign irq = (eoc_pend && eoc_ie_q) || (eos_pend && eos_ie_q);

    assign status = {busy, 1'b0, eos_pend, 1'b0, din, REVISION,
                     1'b0, fifo_full, fifo_empty, 1'b0};

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else if (rd_en) begin
            case (addr)
                A_CTRL_FIFO: rdata <= fifo_dout;
                A_LIST_STAT: rdata <= status;
                default:     rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/ai_scan_seq_chk.sv
module ai_scan_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       conv_start,
    input logic       busy,
    input logic       irq,
    input logic       eoc_ie,
    input logic       eos_ie,
    input logic       fifo_full,
    input logic       fifo_empty,
    input logic [3:0] mux_chan
);
    // R3
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);

    // R3
    start_idle_chk: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> (busy && !$past(busy)));

    // R2
    chan_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(mux_chan));

    // R7
    fifo_flags_chk: assert property (@(posedge clk) disable iff (rst)
        !(fifo_full && fifo_empty));

    // R10
    irq_enable_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (eoc_ie || eos_ie));
endmodule

bind ai_scan_seq ai_scan_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .conv_start (conv_start),
    .busy       (busy),
    .irq        (irq),
    .eoc_ie     (eoc_ie_q),
    .eos_ie     (eos_ie_q),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty),
    .mux_chan   (mux_chan)
);

// File: tb/ai_scan_seq_tb.sv
module ai_scan_seq_tb;
    localparam logic [3:0] REV = 4'h3;
    localparam int FDEPTH = 8;

    logic clk = 1'b0, rst = 1'b1;
    logic wr_en = 0, rd_en = 0, conv_trig = 0, ext_start = 0, adc_valid = 0;
    logic [1:0] addr = 0;
    logic [15:0] wdata = 0, adc_data = 0;
    logic [3:0] din = 4'hA;
    logic [15:0] rdata;
    logic conv_start, unipolar, irq;
    logic [3:0] mux_chan;
    logic [1:0] gain;

    int checks = 0, failures = 0;
    logic [6:0] slot_q[$];
    logic [15:0] data_q[$];
    logic [15:0] last_word = 0;
    logic [6:0] tbl [16];
    int b_first = 0, b_last = 0, b_idx = 0;
    logic b_scan = 0, b_eoc_ie = 0, b_eos_ie = 0, eoc_p = 0, eos_p = 0;

    always #2 clk = ~clk;

    ai_scan_seq #(.REVISION(REV)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .conv_trig(conv_trig),
        .ext_start(ext_start), .adc_valid(adc_valid), .adc_data(adc_data),
        .din(din), .conv_start(conv_start), .mux_chan(mux_chan),
        .gain(gain), .unipolar(unipolar), .irq(irq)
    );

    task automatic check(input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: compares each start strobe against the scoreboard
    always @(negedge clk) begin
        if (!rst && conv_start) begin
            if (slot_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R3 actual=unexpected start expected=none");
            end else begin
                check("R2", {9'd0, unipolar, gain, mux_chan}, {9'd0, slot_q.pop_front()});
            end
        end
    end

    function automatic logic [15:0] exp_status(input logic bsy);
        logic full = (data_q.size() == FDEPTH);
        logic empty = (data_q.size() == 0);
        return {bsy, 1'b0, eos_p, 1'b0, din, REV, 1'b0, full, empty, 1'b0};
    endfunction

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk); rd_en = 1; addr = a;
        @(negedge clk); rd_en = 0; d = rdata;
    endtask

    task automatic set_ctrl(input int first, input int last, input logic gate);
        wr(2'd0, {gate, 3'b0, 4'(last), 4'b0, 4'(first)});
        b_first = first; b_last = last; b_idx = first;
    endtask

    task automatic set_mode(input logic scan, input logic eos_ie, input logic eoc_ie);
        wr(2'd2, {12'd0, scan, 1'b0, eos_ie, eoc_ie});
        b_scan = scan; b_eos_ie = eos_ie; b_eoc_ie = eoc_ie;
    endtask

    task automatic model_result(input logic [15:0] d);
        if (data_q.size() < FDEPTH) data_q.push_back(d);
        eoc_p = 1;
        if (b_scan) begin
            if (b_idx == b_last) begin b_idx = b_first; eos_p = 1; end
            else b_idx = (b_idx + 1) % 16;
        end
    endtask

    task automatic convert(input logic [15:0] d);
        slot_q.push_back(tbl[b_idx]);
        @(negedge clk); conv_trig = 1;
        @(negedge clk); conv_trig = 0; adc_valid = 1; adc_data = d;
        @(negedge clk); adc_valid = 0;
        model_result(d);
        check("R10 irq", {15'd0, irq}, {15'd0, (eoc_p & b_eoc_ie) | (eos_p & b_eos_ie)});
    endtask

    task automatic read_status(input string req);
        logic [15:0] v;
        rd(2'd1, v);
        check(req, v, exp_status(0));
        eoc_p = 0; eos_p = 0;
    endtask

    task automatic read_fifo(input string req);
        logic [15:0] v;
        rd(2'd0, v);
        if (data_q.size() > 0) last_word = data_q.pop_front();
        check(req, v, last_word);
    endtask

    initial begin
        #(4 * 200000);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 / R11 reset state
        @(negedge clk);
        check("R1 irq", {15'd0, irq}, 16'd0);
        check("R1 outputs", {9'd0, unipolar, gain, mux_chan}, 16'd0);
        read_status("R1 R11 status");

        // R2 program the list
        for (int i = 0; i < 16; i++) begin
            tbl[i] = {i[0], 2'(i), 4'((i * 5 + 1) % 16)};
            wr(2'd1, {4'd0, 4'(i), tbl[i][6], 1'b0, tbl[i][5:4], tbl[i][3:0]});
        end

        // R4 scan through slots 0..3 with wrap
        set_mode(1, 1, 0);
        set_ctrl(0, 3, 0);
        for (int k = 0; k < 4; k++) convert(16'h0100 + 16'(k));
        check("R4 irq eos", {15'd0, irq}, 16'd1);
        read_status("R4 R7 status after scan");
        check("R10 irq cleared", {15'd0, irq}, 16'd0);
        for (int k = 0; k < 4; k++) read_fifo("R7 fifo order");
        read_fifo("R8 empty read");
        read_status("R8 status empty");
        convert(16'h0200); // wraps back to slot 0

        // R7 fill to full and drop one
        for (int k = 0; k < 8; k++) convert(16'h0300 + 16'(k));
        read_status("R7 full status");
        for (int k = 0; k < 9; k++) read_fifo("R7 R8 drain");
        read_status("R7 empty after drain");

        // R9 flush
        convert(16'h0400);
        convert(16'h0401);
        rd(2'd3, v);
        data_q.delete();
        read_status("R9 flush empties");

        // R5 nonzero first slot
        set_ctrl(2, 3, 0);
        for (int k = 0; k < 3; k++) convert(16'h0500 + 16'(k));
        read_status("R5 R4 status");

        // R4 stepping disabled: pointer holds
        set_mode(0, 0, 1);
        set_ctrl(5, 9, 0);
        convert(16'h0600);
        convert(16'h0601);
        read_status("R4 hold status");
        check("R10 irq cleared eoc", {15'd0, irq}, 16'd0);

        // R6 external gate
        set_mode(1, 0, 0);
        set_ctrl(0, 1, 1);
        @(negedge clk); conv_trig = 1;
        @(negedge clk); conv_trig = 0;
        @(negedge clk);
        read_status("R6 gated trigger ignored");
        @(negedge clk); ext_start = 1;
        @(negedge clk); ext_start = 0;
        convert(16'h0700);

        // R3 busy flag and trigger during conversion
        slot_q.push_back(tbl[b_idx]);
        @(negedge clk); conv_trig = 1;
        @(negedge clk); conv_trig = 1; rd_en = 1; addr = 2'd1;
        @(negedge clk); conv_trig = 0; rd_en = 0;
        check("R3 busy status", rdata, exp_status(1));
        eoc_p = 0; eos_p = 0;
        adc_valid = 1; adc_data = 16'h0800;
        @(negedge clk); adc_valid = 0;
        model_result(16'h0800);
        read_status("R3 idle after result");

        // R5 control write abandons a conversion
        slot_q.push_back(tbl[b_idx]);
        @(negedge clk); conv_trig = 1;
        @(negedge clk); conv_trig = 0;
        set_ctrl(4, 6, 0);
        @(negedge clk); adc_valid = 1; adc_data = 16'h0900;
        @(negedge clk); adc_valid = 0;
        read_status("R5 abandoned conversion");
        convert(16'h0901);
        read_status("R5 restart slot");

        repeat (3) @(negedge clk);
        check("R3 all starts seen", 16'(slot_q.size()), 16'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule